// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor

This block guesses whether a conditional branch will be taken, early enough for a pipelined fetch unit to redirect without waiting for the branch to execute. The fetch side presents the branch address together with its target and gets the guess back combinationally in the same cycle. Some cycles later the execute stage, once the condition is known, sends back the branch address, the real direction and the guess that was used for it. The block then trains its history table and, when the guess was wrong, raises an annul pulse so that instructions fetched down the wrong path can be squashed.

The history table has one entry per value of a small slice of address bits above the instruction alignment. Each entry holds a two-bit saturating counter and a valid flag. An entry that has never been trained gives no history, so the guess comes from the branch geometry instead: a branch jumping to a lower address (typically a loop closing) is guessed taken, and any other branch is guessed not taken. Once trained, the counter's upper bit is the guess, and a single surprise from a saturated state does not flip it.

Top module: `bdp_top`

## Requirements
- R1: While reset is held and after its release, every entry is invalid, so every lookup returns the static guess until that entry is trained.
- R2: For an untrained entry with `lk_valid` high, `lk_taken` is 1 when `lk_target` is strictly less than `lk_pc` and 0 when the target is equal or higher; `lk_taken` is 0 whenever `lk_valid` is low.
- R3: The first update to an untrained entry marks it valid and loads the counter with 2 if the outcome was taken and 1 if not taken.
- R4: For a trained entry, `lk_taken` is 1 exactly when its counter is 2 or 3, whatever the target.
- R5: An update to a trained entry adds one to the counter on a taken outcome (stopping at 3) and subtracts one on a not-taken outcome (stopping at 0).
- R6: An entry saturated at 3 or 0 keeps its guess after one contrary outcome and changes it after the second consecutive contrary outcome.
- R7: The entry is selected by address bits [ALIGN_BITS+INDEX_BITS-1 : ALIGN_BITS]; addresses that agree in those bits share one entry whatever their other bits.
- R8: When a lookup and an update address the same entry in one cycle, the lookup returns the guess from the state before that update.
- R9: `annul_o` is 1 during the cycle after an update whose `up_pred` differs from `up_taken`, and 0 in every other cycle.
- R10: Lookups never alter the table; with `up_valid` low, the guess for any address stays the same from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Fetch presents a branch for a guess |
| lk_pc | input | PC_W | Address of the branch being fetched |
| lk_target | input | PC_W | Branch target address |
| lk_taken | output | 1 | Guessed direction, 1 = taken |
| up_valid | input | 1 | Execute reports a resolved branch |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Actual direction, 1 = taken |
| up_pred | input | 1 | Direction that was guessed for this branch |
| annul_o | output | 1 | Wrong-path squash pulse, one cycle after a wrong guess |

## Verification
The awkward case is the same-cycle collision in which a lookup and an update target one entry, since the guess must still reflect the pre-update counter; the bench makes every training step a collision by looking up the same address it is updating, so the read-before-write order is checked at every counter value including the saturation points. Saturation hysteresis needs several consecutive outcomes on one entry, so each entry is walked through a taken run, a not-taken run and alternating patterns while a bench model of the counters predicts every guess and every annul pulse. Aliasing is reached by training with one address and probing with another that differs only outside the index slice.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_MAX = 2'd3;
  localparam ctr_t CTR_MIN = 2'd0;
  localparam ctr_t CTR_WEAK_T = 2'd2;
  localparam ctr_t CTR_WEAK_N = 2'd1;

  // Direction carried by a counter value
  function automatic logic ctr_dir(input ctr_t c);
    return c[1];
  endfunction

  // Value loaded when an entry is trained for the first time
  function automatic ctr_t ctr_seed(input logic taken);
    return taken ? CTR_WEAK_T : CTR_WEAK_N;
  endfunction

  // Saturating step toward the outcome
  function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
    ctr_t r;
    if (taken) r = (c == CTR_MAX) ? CTR_MAX : ctr_t'(c + 2'd1);
    else       r = (c == CTR_MIN) ? CTR_MIN : ctr_t'(c - 2'd1);
    return r;
  endfunction

endpackage

// File: rtl/bdp_table.sv
module bdp_table #(
  parameter int INDEX_BITS = 4,
  localparam int ENTRIES = 1 << INDEX_BITS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [INDEX_BITS-1:0]   rd_idx,
  output logic                    rd_vld,
  output bdp_pkg::ctr_t           rd_ctr,
  input  logic                    wr_en,
  input  logic [INDEX_BITS-1:0]   wr_idx,
  input  bdp_pkg::ctr_t           wr_ctr,
  output logic                    wr_old_vld,
  output bdp_pkg::ctr_t           wr_old_ctr,
  output logic [ENTRIES-1:0]      vld_vec,
  output logic [2*ENTRIES-1:0]    ctr_flat
);

  bdp_pkg::ctr_t ctr_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_idx == INDEX_BITS'(e));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[e] <= 1'b0;
        ctr_q[e] <= bdp_pkg::CTR_MIN;
      end else if (hit) begin
        vld_q[e] <= 1'b1;
        ctr_q[e] <= wr_ctr;
      end
    end

    assign ctr_flat[2*e +: 2] = ctr_q[e];
  end

  assign vld_vec    = vld_q;
  assign rd_vld     = vld_q[rd_idx];
  assign rd_ctr     = ctr_q[rd_idx];
  assign wr_old_vld = vld_q[wr_idx];
  assign wr_old_ctr = ctr_q[wr_idx];

endmodule

// File: rtl/bdp_lookup.sv
module bdp_lookup #(
  parameter int PC_W = 16
) (
  input  logic            req,
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] target,
  input  logic            hit_vld,
  input  bdp_pkg::ctr_t   hit_ctr,
  output logic            taken
);

  // Backward branches (loops) are guessed taken on first sight
  function automatic logic static_guess(input logic [PC_W-1:0] p,
                                        input logic [PC_W-1:0] t);
    return t < p;
  endfunction

  always_comb begin
    if (!req)         taken = 1'b0;
    else if (hit_vld) taken = bdp_pkg::ctr_dir(hit_ctr);
    else              taken = static_guess(pc, target);
  end

endmodule

// File: rtl/bdp_resolve.sv
module bdp_resolve (
  input  logic          upd,
  input  logic          old_vld,
  input  bdp_pkg::ctr_t old_ctr,
  input  logic          actual,
  input  logic          guessed,
  output bdp_pkg::ctr_t new_ctr,
  output logic          wrong
);

  always_comb begin
    if (old_vld) new_ctr = bdp_pkg::ctr_step(old_ctr, actual);
    else         new_ctr = bdp_pkg::ctr_seed(actual);
  end

  assign wrong = upd && (guessed != actual);

endmodule

// File: rtl/bdp_top.sv
module bdp_top #(
  parameter int PC_W       = 16,
  parameter int INDEX_BITS = 4,
  parameter int ALIGN_BITS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [PC_W-1:0] lk_pc,
  input  logic [PC_W-1:0] lk_target,
  output logic            lk_taken,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic            up_pred,
  output logic            annul_o
);

  localparam int ENTRIES = 1 << INDEX_BITS;

  // Named internal events, also observed by the checker
  logic [INDEX_BITS-1:0] lk_idx;
  logic [INDEX_BITS-1:0] up_idx;
  logic                  lk_hit_vld;
  bdp_pkg::ctr_t         lk_hit_ctr;
  logic                  up_old_vld;
  bdp_pkg::ctr_t         up_old_ctr;
  bdp_pkg::ctr_t         up_new_ctr;
  logic                  up_wrong;
  logic [ENTRIES-1:0]    vld_vec;
  logic [2*ENTRIES-1:0]  ctr_flat;
  logic                  annul_q;

  assign lk_idx = lk_pc[ALIGN_BITS +: INDEX_BITS];
  assign up_idx = up_pc[ALIGN_BITS +: INDEX_BITS];

  bdp_table #(.INDEX_BITS(INDEX_BITS)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_idx     (lk_idx),
    .rd_vld     (lk_hit_vld),
    .rd_ctr     (lk_hit_ctr),
    .wr_en      (up_valid),
    .wr_idx     (up_idx),
    .wr_ctr     (up_new_ctr),
    .wr_old_vld (up_old_vld),
    .wr_old_ctr (up_old_ctr),
    .vld_vec    (vld_vec),
    .ctr_flat   (ctr_flat)
  );

  bdp_lookup #(.PC_W(PC_W)) u_lookup (
    .req     (lk_valid),
    .pc      (lk_pc),
    .target  (lk_target),
    .hit_vld (lk_hit_vld),
    .hit_ctr (lk_hit_ctr),
    .taken   (lk_taken)
  );

  bdp_resolve u_resolve (
    .upd     (up_valid),
    .old_vld (up_old_vld),
    .old_ctr (up_old_ctr),
    .actual  (up_taken),
    .guessed (up_pred),
    .new_ctr (up_new_ctr),
    .wrong   (up_wrong)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) annul_q <= 1'b0;
    else        annul_q <= up_wrong;
  end

  assign annul_o = annul_q;

endmodule

// File: rtl/bdp_checker.sv
module bdp_checker #(
  parameter int PC_W       = 16,
  parameter int INDEX_BITS = 4,
  localparam int ENTRIES = 1 << INDEX_BITS
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   lk_valid,
  input logic [PC_W-1:0]        lk_pc,
  input logic [PC_W-1:0]        lk_target,
  input logic                   lk_taken,
  input logic                   up_valid,
  input logic                   up_taken,
  input logic                   up_pred,
  input logic                   annul_o,
  input logic [INDEX_BITS-1:0]  up_idx,
  input logic                   lk_hit_vld,
  input logic [1:0]             lk_hit_ctr,
  input logic                   up_old_vld,
  input logic [1:0]             up_old_ctr,
  input logic [ENTRIES-1:0]     vld_vec,
  input logic [2*ENTRIES-1:0]   ctr_flat
);

  logic                  p_upd, p_act, p_pred, p_old_vld;
  logic [1:0]            p_old_ctr;
  logic [INDEX_BITS-1:0] p_idx;
  logic [1:0]            cur_ctr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_upd <= 1'b0; p_act <= 1'b0; p_pred <= 1'b0;
      p_old_vld <= 1'b0; p_old_ctr <= 2'd0; p_idx <= '0;
    end else begin
      p_upd <= up_valid; p_act <= up_taken; p_pred <= up_pred;
      p_old_vld <= up_old_vld; p_old_ctr <= up_old_ctr; p_idx <= up_idx;
    end
  end

  assign cur_ctr = ctr_flat[{p_idx, 1'b0} +: 2];

  AST_STATIC_GUESS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && !lk_hit_vld |-> lk_taken == (lk_target < lk_pc)); // R2

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !lk_taken); // R2

  AST_TRAINED_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_hit_vld |-> lk_taken == (lk_hit_ctr >= 2'd2)); // R4

  AST_MARK_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    p_upd |-> vld_vec[p_idx]); // R3

  AST_SEED_WEAK: assert property (@(posedge clk) disable iff (!rst_n)
    p_upd && !p_old_vld |-> cur_ctr == (p_act ? 2'd2 : 2'd1)); // R3

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    p_upd && p_old_vld && p_act |-> cur_ctr != 2'd0 && cur_ctr >= p_old_ctr); // R5

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    p_upd && p_old_vld && !p_act |-> cur_ctr != 2'd3 && cur_ctr <= p_old_ctr); // R5

  AST_QUIET_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(vld_vec) && $stable(ctr_flat)); // R10

  AST_ANNUL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    annul_o == (p_upd && (p_pred != p_act))); // R9

endmodule

bind bdp_top bdp_checker #(.PC_W(PC_W), .INDEX_BITS(INDEX_BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_valid   (lk_valid),
  .lk_pc      (lk_pc),
  .lk_target  (lk_target),
  .lk_taken   (lk_taken),
  .up_valid   (up_valid),
  .up_taken   (up_taken),
  .up_pred    (up_pred),
  .annul_o    (annul_o),
  .up_idx     (up_idx),
  .lk_hit_vld (lk_hit_vld),
  .lk_hit_ctr (lk_hit_ctr),
  .up_old_vld (up_old_vld),
  .up_old_ctr (up_old_ctr),
  .vld_vec    (vld_vec),
  .ctr_flat   (ctr_flat)
);

// File: tb/bdp_top_tb.sv
module bdp_top_tb;

  localparam int PC_W = 16;
  localparam int IB   = 4;
  localparam int AB   = 2;
  localparam int N    = 1 << IB;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            lk_valid, up_valid, up_taken, up_pred;
  logic [PC_W-1:0] lk_pc, lk_target, up_pc;
  logic            lk_taken, annul_o;

  int errors = 0;
  int checks = 0;

  int  mctr [N];
  bit  mvld [N];
  bit  pv, pt, pann;
  int  pidx;

  always #10 clk = ~clk;

  bdp_top #(.PC_W(PC_W), .INDEX_BITS(IB), .ALIGN_BITS(AB)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_target(lk_target), .lk_taken(lk_taken),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_pred(up_pred),
    .annul_o(annul_o)
  );

  function automatic logic [PC_W-1:0] mkpc(int hi, int idx, int lo);
    return PC_W'((hi * 64) + (idx * 4) + lo);
  endfunction

  function automatic int idx_of(logic [PC_W-1:0] pc);
    return (int'(pc) / 4) % N;
  endfunction

  function automatic bit model_guess(logic [PC_W-1:0] pc, logic [PC_W-1:0] tgt);
    int i = idx_of(pc);
    if (mvld[i]) return mctr[i] > 1;
    return int'(tgt) < int'(pc);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // One bench cycle: settle previous update into the model, drive, sample lookup
  task automatic cyc(bit lv, logic [PC_W-1:0] lpc, logic [PC_W-1:0] ltg,
                     bit uv, logic [PC_W-1:0] upc, bit ut, bit up, string req);
    bit exp;
    @(negedge clk);
    check(annul_o == pann, "R9", annul_o, pann);
    if (pv) begin
      if (!mvld[pidx]) begin
        mctr[pidx] = pt ? 2 : 1;
        mvld[pidx] = 1'b1;
      end else if (pt) begin
        if (mctr[pidx] < 3) mctr[pidx] = mctr[pidx] + 1;
      end else begin
        if (mctr[pidx] > 0) mctr[pidx] = mctr[pidx] - 1;
      end
    end
    lk_valid = lv; lk_pc = lpc; lk_target = ltg;
    up_valid = uv; up_pc = upc; up_taken = ut; up_pred = up;
    pv = uv; pt = ut; pidx = idx_of(upc); pann = uv && (up != ut);
    #5;
    exp = lv ? model_guess(lpc, ltg) : 1'b0;
    check(lk_taken == exp, req, lk_taken, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    lk_valid = 0; up_valid = 0; up_taken = 0; up_pred = 0;
    lk_pc = '0; lk_target = '0; up_pc = '0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < N; i++) begin mvld[i] = 0; mctr[i] = 0; end
    pv = 0; pt = 0; pidx = 0; pann = 0;
    rst_n = 1'b1;
  endtask

  // Train one entry: lookup and update the same address in the same cycle
  task automatic train(logic [PC_W-1:0] pc, bit t, string req);
    bit g;
    g = model_guess(pc, pc + 16'd8);
    cyc(1, pc, pc + 16'd8, 1, pc, t, g, req);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    lk_valid = 0; up_valid = 0; up_taken = 0; up_pred = 0;
    lk_pc = '0; lk_target = '0; up_pc = '0;
    do_reset();

    // R1 / R2: static guesses over every entry, backward, forward, equal
    for (int i = 0; i < N; i++) begin
      cyc(1, mkpc(1, i, 0), mkpc(1, i, 0) - 16'd4, 0, '0, 0, 0, "R1");
      cyc(1, mkpc(1, i, 0), mkpc(1, i, 0) + 16'd8, 0, '0, 0, 0, "R2");
      cyc(1, mkpc(1, i, 0), mkpc(1, i, 0), 0, '0, 0, 0, "R2");
      cyc(0, mkpc(1, i, 0), mkpc(1, i, 0) - 16'd4, 0, '0, 0, 0, "R2");
    end

    // R3: first training seeds the weak state, checked against the static guess
    train(mkpc(2, 5, 0), 1'b0, "R3");
    cyc(1, mkpc(2, 5, 0), mkpc(2, 5, 0) - 16'd4, 0, '0, 0, 0, "R3");
    train(mkpc(2, 6, 0), 1'b1, "R3");
    cyc(1, mkpc(2, 6, 0), mkpc(2, 6, 0) + 16'd8, 0, '0, 0, 0, "R3");

    // R6: hysteresis from the saturated taken state on entry 0
    do_reset();
    for (int k = 0; k < 4; k++) train(mkpc(0, 0, 0), 1'b1, "R5");
    train(mkpc(0, 0, 0), 1'b0, "R6");
    cyc(1, mkpc(0, 0, 0), mkpc(0, 0, 0) + 16'd8, 0, '0, 0, 0, "R6");
    train(mkpc(0, 0, 0), 1'b0, "R6");
    cyc(1, mkpc(0, 0, 0), mkpc(0, 0, 0) - 16'd4, 0, '0, 0, 0, "R6");
    for (int k = 0; k < 4; k++) train(mkpc(0, 0, 0), 1'b0, "R5");
    train(mkpc(0, 0, 0), 1'b1, "R6");
    cyc(1, mkpc(0, 0, 0), mkpc(0, 0, 0) - 16'd4, 0, '0, 0, 0, "R6");

    // R4 / R5 / R8: sweep every entry through runs and alternations
    for (int i = 0; i < N; i++) begin
      for (int s = 0; s < 14; s++) begin
        bit t = ((s < 4) || (s >= 10 && (s % 2 == 0)) || ((i >> (s % 4)) & 1) == 1 && s >= 8)
                ? 1'b1 : 1'b0;
        train(mkpc(i, i, 0), t, "R8");
      end
      cyc(1, mkpc(i + 1, i, 0), mkpc(i + 1, i, 0) - 16'd4, 0, '0, 0, 0, "R4");
    end

    // R7: aliasing through bits outside the index slice
    do_reset();
    train(mkpc(3, 9, 0), 1'b1, "R7");
    train(mkpc(3, 9, 0), 1'b1, "R7");
    cyc(1, mkpc(32, 9, 2), mkpc(32, 9, 2) + 16'd8, 0, '0, 0, 0, "R7");
    cyc(1, mkpc(3, 10, 0), mkpc(3, 10, 0) + 16'd8, 0, '0, 0, 0, "R7");

    // R9: deliberately wrong and right reported guesses
    cyc(0, '0, '0, 1, mkpc(0, 3, 0), 1'b1, 1'b0, "R9");
    cyc(0, '0, '0, 1, mkpc(0, 3, 0), 1'b1, 1'b1, "R9");
    cyc(0, '0, '0, 1, mkpc(0, 3, 0), 1'b0, 1'b1, "R9");
    cyc(0, '0, '0, 0, '0, 0, 0, "R9");

    // R10: lookups alone leave all guesses unchanged
    for (int k = 0; k < 3 * N; k++)
      cyc(1, mkpc(k, k % N, k % 4), mkpc(k, k % N, k % 4) + 16'(k * 37 % 200) - 16'd90,
          0, '0, 0, 0, "R10");

    // R1: a fresh reset forgets all training
    do_reset();
    for (int i = 0; i < N; i++)
      cyc(1, mkpc(4, i, 0), mkpc(4, i, 0) + 16'd8, 0, '0, 0, 0, "R1");
    cyc(0, '0, '0, 0, '0, 0, 0, "R9");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule